// File: doc/BRIEF.md
# Line-Aligned DMA Request Splitter

The block takes one DMA transfer command at a time: read or write, a start byte address, a byte length and a transfer tag. It breaks the transfer into memory requests that never span a cache-line boundary. The generated requests wait in a queue and go out one at a time on a request channel. Every request carries the shared tag, the read/write flag, its address and byte count, and its byte offset inside the transfer buffer. A write path uses that offset to index its data.

The request channel works by offers. The block raises `req_valid` for one cycle with the queue head on the request fields. If `req_ready` is high in that cycle, the request is taken. If it is low, the request stays at the head of the queue and the block goes silent until the far side pulses `req_retry`. After every accepted request, at least one idle cycle follows.

`chunk_queued` pulses once for each request placed in the queue, so an outstanding-request counter elsewhere can count up. That counter counts down on responses, which this block does not handle.

Top module: `dma_split_issuer`

## Requirements
- R1: A transfer of length L at address A becomes requests in which each request ends at the next multiple of LINE_BYTES (default 64) or at A+L, whichever comes first. Every request after the first therefore starts on a line boundary, and only the first may be short for alignment.
- R2: The `req_offset` of each request is the sum of the byte counts of the earlier requests of the same transfer. The first request has offset 0.
- R3: Every request of a transfer carries that transfer's `cmd_tag` on `req_tag` and its `cmd_write` on `req_write` (1 = write, 0 = read).
- R4: `chunk_queued` is high for exactly one cycle per request placed in the queue. The number of pulses for a transfer equals the number of requests it produces.
- R5: Requests leave in queue order. A request is offered by holding `req_valid` high for one cycle and is taken when `req_ready` is high in that same cycle.
- R6: A refused offer keeps the request at the head of the queue and `req_valid` stays low until a `req_retry` pulse arrives. The same request is offered again in the cycle after that pulse.
- R7: In the cycle after a taken request, `req_valid` is low.
- R8: `req_retry` has no effect unless the block is waiting after a refusal. This includes a pulse that coincides with the refused offer itself.
- R9: `cmd_ready` is low while a command is still being split, and low while the queue has fewer free entries than the worst-case request count of a maximum-length transfer (17 with the defaults).
- R10: A command with `cmd_len` = 0 is consumed and produces no request and no `chunk_queued` pulse.
- R11: After reset, `req_valid` and `chunk_queued` are low and `cmd_ready` is high.
- R12: A command accepted while the block waits for a retry has its requests appended behind the waiting ones. No request goes out before the retry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Transfer command present |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_write | input | 1 | 1 = write transfer, 0 = read |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Transfer length in bytes |
| cmd_tag | input | TAG_W | Transfer identifier |
| req_valid | output | 1 | One-cycle request offer |
| req_ready | input | 1 | Offer taken in this cycle |
| req_retry | input | 1 | Pulse allowing a refused request to be offered again |
| req_write | output | 1 | Request direction |
| req_addr | output | ADDR_W | Request byte address |
| req_size | output | log2(LINE_BYTES)+1 | Request byte count |
| req_offset | output | LEN_W | Byte offset of the request in the transfer buffer |
| req_tag | output | TAG_W | Tag of the owning transfer |
| chunk_queued | output | 1 | One pulse per request queued |

## Verification
The splitter is tried with several kinds of transfer: aligned and exactly one line long; unaligned and spanning two lines; a single byte; two bytes straddling a boundary; a full-length aligned transfer; the worst-case 17-request transfer; and transfers that end exactly on a boundary or one byte past it. Together these separate a correct minimum of remaining bytes and room in the line from off-by-one errors at the boundary and from wrong first-chunk lengths. Refusal tests hold the channel low to show that the head stays put. They also show that a retry arriving together with the refusal is ignored, and that a command taken during the wait is queued but not issued. The worst-case transfer is also used to show that commands are held off while the queue lacks room.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

  typedef enum logic [1:0] {
    ISS_READY      = 2'd0,
    ISS_RETRY_WAIT = 2'd1,
    ISS_GAP        = 2'd2
  } iss_state_e;

  // Bytes left in the current line, counted from the given low address bits.
  function automatic int unsigned line_room(input int unsigned addr_lo,
                                            input int unsigned line_bytes);
    return line_bytes - (addr_lo % line_bytes);
  endfunction

  // Length of the next request: the smaller of what remains and the room in the line.
  function automatic int unsigned chunk_bytes(input int unsigned addr_lo,
                                              input int unsigned remain,
                                              input int unsigned line_bytes);
    int unsigned room;
    room = line_room(addr_lo, line_bytes);
    return (remain < room) ? remain : room;
  endfunction

  // Worst case: an unaligned start one byte before a boundary.
  function automatic int unsigned worst_chunks(input int unsigned max_len,
                                               input int unsigned line_bytes);
    return (max_len + 2 * line_bytes - 2) / line_bytes;
  endfunction

endpackage

// File: rtl/dma_split_gen.sv
module dma_split_gen
  import dma_split_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 10,
  parameter int unsigned TAG_W      = 4,
  parameter int unsigned LINE_BYTES = 64,
  localparam int unsigned OFF_W     = $clog2(LINE_BYTES),
  localparam int unsigned SIZE_W    = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              busy_o,
  output logic              push_o,
  output logic              chunk_write_o,
  output logic [ADDR_W-1:0] chunk_addr_o,
  output logic [SIZE_W-1:0] chunk_size_o,
  output logic [LEN_W-1:0]  chunk_off_o,
  output logic [TAG_W-1:0]  chunk_tag_o
);

  logic              busy_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  left_q;
  logic [LEN_W-1:0]  off_q;
  logic [TAG_W-1:0]  tag_q;
  logic [SIZE_W-1:0] size_w;
  logic              last_w;

  always_comb begin
    size_w = SIZE_W'(chunk_bytes(32'(addr_q[OFF_W-1:0]), 32'(left_q), LINE_BYTES));
    last_w = (32'(left_q) == 32'(size_w));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
      left_q  <= '0;
      off_q   <= '0;
      tag_q   <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      write_q <= write_i;
      addr_q  <= addr_i;
      left_q  <= len_i;
      off_q   <= '0;
      tag_q   <= tag_i;
    end else if (busy_q) begin
      addr_q <= addr_q + ADDR_W'(size_w);
      left_q <= left_q - LEN_W'(size_w);
      off_q  <= off_q + LEN_W'(size_w);
      if (last_w) busy_q <= 1'b0;
    end
  end

  assign busy_o        = busy_q;
  assign push_o        = busy_q;
  assign chunk_write_o = write_q;
  assign chunk_addr_o  = addr_q;
  assign chunk_size_o  = size_w;
  assign chunk_off_o   = off_q;
  assign chunk_tag_o   = tag_q;

  // R1: a request never reaches past the end of its line and is never empty
  p_chunk_in_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (size_w != '0) && (32'(addr_q[OFF_W-1:0]) + 32'(size_w) <= LINE_BYTES))
    else $error("chunk crosses line");

  // R1: every request after the first starts on a line boundary
  p_later_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !last_w) |=> busy_q && (addr_q[OFF_W-1:0] == '0))
    else $error("later chunk unaligned");

  // R9: a new command is never loaded on top of one being split
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q)
    else $error("start while busy");

endmodule

// File: rtl/dma_split_fifo.sv
module dma_split_fifo #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned DEPTH  = 32,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CNT_W-1:0] count_o
);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q;
  logic [PTR_W-1:0] rd_q;
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
    end else begin
      if (push_i) wr_q <= (32'(wr_q) == DEPTH - 1) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_q <= (32'(rd_q) == DEPTH - 1) ? '0 : rd_q + 1'b1;
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_o  = mem_q[rd_q];
  assign count_o = count_q;

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (32'(count_q) < DEPTH))
    else $error("queue overflow");

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (count_q != '0))
    else $error("queue underflow");

endmodule

// File: rtl/dma_split_sender.sv
module dma_split_sender
  import dma_split_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic head_valid_i,
  input  logic req_ready_i,
  input  logic retry_i,
  output logic req_valid_o,
  output logic pop_o
);

  iss_state_e state_q, state_d;
  logic       offer_w;
  logic       taken_w;
  logic       refused_w;

  always_comb begin
    offer_w   = (state_q == ISS_READY) && head_valid_i;
    taken_w   = offer_w && req_ready_i;
    refused_w = offer_w && !req_ready_i;
    state_d   = state_q;
    case (state_q)
      ISS_READY: begin
        if (taken_w)        state_d = ISS_GAP;
        else if (refused_w) state_d = ISS_RETRY_WAIT;
      end
      ISS_RETRY_WAIT: if (retry_i) state_d = ISS_READY;
      ISS_GAP:        state_d = ISS_READY;
      default:        state_d = ISS_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ISS_READY;
    else        state_q <= state_d;
  end

  assign req_valid_o = offer_w;
  assign pop_o       = taken_w;

  p_gap_after_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    taken_w |=> !req_valid_o)
    else $error("no gap after accepted request");

  p_silent_in_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    refused_w |=> !req_valid_o)
    else $error("offer right after refusal");

  p_reoffer_on_retry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ISS_RETRY_WAIT && retry_i) |=> req_valid_o)
    else $error("no reoffer after retry");

  p_retry_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (refused_w && retry_i) |=> (state_q == ISS_RETRY_WAIT))
    else $error("retry taken outside wait");

endmodule

// File: rtl/dma_split_issuer.sv
module dma_split_issuer
  import dma_split_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned LEN_W       = 10,
  parameter int unsigned TAG_W       = 4,
  parameter int unsigned LINE_BYTES  = 64,
  parameter int unsigned QUEUE_DEPTH = 32,
  localparam int unsigned SIZE_W     = $clog2(LINE_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [TAG_W-1:0]  cmd_tag,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              req_retry,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [SIZE_W-1:0] req_size,
  output logic [LEN_W-1:0]  req_offset,
  output logic [TAG_W-1:0]  req_tag,
  output logic              chunk_queued
);

  localparam int unsigned MAX_CHUNKS = worst_chunks((2 ** LEN_W) - 1, LINE_BYTES);
  localparam int unsigned ENTRY_W    = 1 + ADDR_W + SIZE_W + LEN_W + TAG_W;
  localparam int unsigned CNT_W      = $clog2(QUEUE_DEPTH + 1);

  logic              gen_busy;
  logic              gen_push;
  logic              gen_start;
  logic              c_write;
  logic [ADDR_W-1:0] c_addr;
  logic [SIZE_W-1:0] c_size;
  logic [LEN_W-1:0]  c_off;
  logic [TAG_W-1:0]  c_tag;
  logic [ENTRY_W-1:0] q_in;
  logic [ENTRY_W-1:0] q_head;
  logic [CNT_W-1:0]  q_count;
  logic              q_pop;
  logic              room_ok;

  assign room_ok   = (QUEUE_DEPTH - 32'(q_count)) >= MAX_CHUNKS;
  assign cmd_ready = !gen_busy && room_ok;
  assign gen_start = cmd_valid && cmd_ready && (cmd_len != '0);

  dma_split_gen #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W), .LINE_BYTES(LINE_BYTES)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .start_i(gen_start),
    .write_i(cmd_write), .addr_i(cmd_addr), .len_i(cmd_len), .tag_i(cmd_tag),
    .busy_o(gen_busy), .push_o(gen_push),
    .chunk_write_o(c_write), .chunk_addr_o(c_addr), .chunk_size_o(c_size),
    .chunk_off_o(c_off), .chunk_tag_o(c_tag)
  );

  assign q_in = {c_write, c_addr, c_size, c_off, c_tag};

  dma_split_fifo #(.WIDTH(ENTRY_W), .DEPTH(QUEUE_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push_i(gen_push), .data_i(q_in),
    .pop_i(q_pop), .head_o(q_head), .count_o(q_count)
  );

  dma_split_sender u_send (
    .clk(clk), .rst_n(rst_n), .head_valid_i(q_count != '0),
    .req_ready_i(req_ready), .retry_i(req_retry),
    .req_valid_o(req_valid), .pop_o(q_pop)
  );

  assign {req_write, req_addr, req_size, req_offset, req_tag} = q_head;
  assign chunk_queued = gen_push;

  // R6: a refused request is still at the head in the next cycle
  p_head_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> $stable(q_head))
    else $error("refused head changed");

  // R10: a zero-length command starts no splitting
  p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_len == '0) |=> !chunk_queued)
    else $error("zero-length produced a chunk");

endmodule

// File: tb/tb_dma_split_issuer.sv
`timescale 1ns/100ps
module tb_dma_split_issuer;

  localparam int LINE = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [31:0] cmd_addr = '0;
  logic [9:0]  cmd_len = '0;
  logic [3:0]  cmd_tag = '0;
  logic        cmd_ready;
  logic        req_valid, req_write, chunk_queued;
  logic        req_ready = 1'b0, req_retry = 1'b0;
  logic [31:0] req_addr;
  logic [6:0]  req_size;
  logic [9:0]  req_offset;
  logic [3:0]  req_tag;

  int errors = 0;
  int checks = 0;
  int pulses = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma_split_issuer dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_tag(cmd_tag),
    .req_valid(req_valid), .req_ready(req_ready), .req_retry(req_retry),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_offset(req_offset), .req_tag(req_tag), .chunk_queued(chunk_queued)
  );

  always @(negedge clk) if (rst_n && chunk_queued) pulses++;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // {write, tag, len, addr, expected request count}
  localparam logic [54:0] VECS [8] = '{
    {1'b0, 4'd1, 10'd64,   32'h0000_1000, 8'd1},
    {1'b0, 4'd2, 10'd100,  32'h0000_1010, 8'd2},
    {1'b1, 4'd3, 10'd1,    32'h0000_2003, 8'd1},
    {1'b0, 4'd4, 10'd2,    32'h0000_203F, 8'd2},
    {1'b1, 4'd5, 10'd1023, 32'h0000_3000, 8'd16},
    {1'b0, 4'd6, 10'd1023, 32'h0000_303F, 8'd17},
    {1'b1, 4'd7, 10'd32,   32'h0000_4020, 8'd1},
    {1'b0, 4'd8, 10'd33,   32'h0000_4020, 8'd2}
  };

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic send_cmd(input bit w, input logic [31:0] a, input int l, input logic [3:0] t);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_len = 10'(l); cmd_tag = t;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Walks the expected requests of one transfer; req_ready must be high.
  task automatic collect(input longint a, input longint l, input logic [3:0] t,
                         input bit w, input int n_exp);
    longint cur, done, bound, sz;
    int got;
    bit prev;
    cur = a; done = 0; got = 0; prev = 1'b0;
    for (int cyc = 0; cyc < 400 && done < l; cyc++) begin
      if (req_valid) begin
        bound = ((cur / LINE) + 1) * LINE;
        sz = (bound - cur < l - done) ? bound - cur : l - done;
        chk(!prev, "R7", "back-to-back offer", 1, 0);
        chk(longint'(req_addr) == cur, "R1", "addr", longint'(req_addr), cur);
        chk(longint'(req_size) == sz, "R1", "size", longint'(req_size), sz);
        chk(longint'(req_offset) == done, "R2", "offset", longint'(req_offset), done);
        chk(req_tag == t && req_write == w, "R3", "tag/write",
            longint'({req_write, req_tag}), longint'({w, t}));
        cur = cur + sz; done = done + sz; got++;
      end
      prev = req_valid;
      @(negedge clk);
    end
    chk(got == n_exp, "R5", "request count", got, n_exp);
  endtask

  initial begin
    int p0, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(!req_valid && !chunk_queued && cmd_ready, "R11", "reset outputs",
        longint'({req_valid, chunk_queued, cmd_ready}), 1);

    // Table walk: R1 R2 R3 R4 R5 R7
    req_ready = 1'b1;
    for (int i = 0; i < 8; i++) begin
      p0 = pulses;
      send_cmd(VECS[i][54], VECS[i][39:8], int'(VECS[i][49:40]), VECS[i][53:50]);
      collect(longint'(VECS[i][39:8]), longint'(VECS[i][49:40]), VECS[i][53:50],
              VECS[i][54], int'(VECS[i][7:0]));
      repeat (3) @(negedge clk);
      chk(pulses - p0 == int'(VECS[i][7:0]), "R4", "queued pulses", pulses - p0,
          int'(VECS[i][7:0]));
    end

    // R10: zero-length command
    p0 = pulses;
    send_cmd(1'b0, 32'h8000, 0, 4'd3);
    n = 0;
    for (int i = 0; i < 5; i++) begin
      if (req_valid) n++;
      @(negedge clk);
    end
    chk(n == 0 && pulses == p0, "R10", "zero-length output", n + pulses - p0, 0);
    chk(cmd_ready, "R10", "ready after zero-length", longint'(cmd_ready), 1);

    // R8: retry while idle and empty has no effect
    req_retry = 1'b1; @(negedge clk); req_retry = 1'b0;
    @(negedge clk);
    chk(!req_valid, "R8", "idle retry", longint'(req_valid), 0);

    // R6/R8/R12: refusal, coincident retry, command during wait
    req_ready = 1'b0;
    p0 = pulses;
    send_cmd(1'b0, 32'h5010, 100, 4'd5);
    n = 0;
    while (!req_valid && n < 50) begin @(negedge clk); n++; end
    chk(req_valid && req_addr == 32'h5010, "R5", "first offer",
        longint'(req_addr), 32'h5010);
    req_retry = 1'b1;
    @(negedge clk);
    req_retry = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk(!req_valid, "R8", "silent after refusal with retry", longint'(req_valid), 0);
      @(negedge clk);
    end
    send_cmd(1'b1, 32'h7000, 8, 4'd9);
    for (int i = 0; i < 4; i++) begin
      chk(!req_valid, "R12", "no issue before retry", longint'(req_valid), 0);
      @(negedge clk);
    end
    chk(pulses - p0 == 3, "R4", "pulses during wait", pulses - p0, 3);
    req_ready = 1'b1; req_retry = 1'b1;
    @(negedge clk);
    req_retry = 1'b0;
    chk(req_valid && req_addr == 32'h5010 && req_size == 7'd48 && req_offset == 10'd0,
        "R6", "held head reoffered", longint'(req_addr), 32'h5010);
    @(negedge clk);
    chk(!req_valid, "R7", "gap after take", longint'(req_valid), 0);
    @(negedge clk);
    chk(req_valid && req_addr == 32'h5040 && req_size == 7'd52 && req_offset == 10'd48
        && req_tag == 4'd5, "R2", "second chunk", longint'(req_offset), 48);
    @(negedge clk);
    @(negedge clk);
    chk(req_valid && req_addr == 32'h7000 && req_size == 7'd8 && req_write
        && req_tag == 4'd9, "R12", "appended command", longint'(req_addr), 32'h7000);
    repeat (3) @(negedge clk);

    // R9: busy splitting and queue without worst-case room
    req_ready = 1'b0;
    send_cmd(1'b0, 32'h303F, 1023, 4'd2);
    chk(!cmd_ready, "R9", "ready while splitting", longint'(cmd_ready), 0);
    repeat (25) @(negedge clk);
    chk(!cmd_ready, "R9", "ready with 17 queued", longint'(cmd_ready), 0);
    req_ready = 1'b1; req_retry = 1'b1;
    @(negedge clk);
    req_retry = 1'b0;
    collect(64'h303F, 1023, 4'd2, 1'b0, 17);
    repeat (3) @(negedge clk);
    chk(cmd_ready, "R9", "ready after drain", longint'(cmd_ready), 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule